// File: doc/BRIEF.md
# Handshaked Multi-Bit Word Crossing

This block moves a data word from one clock domain to a second, unrelated clock domain without ever passing the data bits through a synchronizer. The sending side registers the word first. One cycle later it raises a single request flop. Only that request bit is synchronized into the receiving domain. While the request is pending, the registered word stays frozen, so the receiving side can sample it safely with a plain enable register.

The receiver detects the rising edge of its synchronized request. On that edge it loads the word through a recirculating capture register and raises a one-cycle output strobe. It then returns an acknowledge bit, which is synchronized back into the sending domain. The exchange is four-phase: request rises, acknowledge rises, request falls, acknowledge falls. Only after the last phase does the sender accept another word.

On the sending side the block offers a valid/ready input. On the receiving side it offers a data bus with a valid strobe. Exactly one word is in flight at a time.

Top module: `word_handoff_cdc`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_data` is all zeros.
- R2: A word is accepted at a rising `src_clk` edge where `in_valid` and `in_ready` are both 1. From the next cycle on, `in_ready` is 0 until the handshake completes.
- R3: While `in_ready` is 0, `in_valid` and `in_data` have no effect: no extra word is delivered, and the delivered word is the one that was accepted.
- R4: Each accepted word yields exactly one `out_valid` pulse, one `dst_clk` cycle wide, with `out_data` equal to that word in the same cycle.
- R5: `out_data` keeps the last delivered word until the next `out_valid` pulse.
- R6: The registered source word does not change while the request is high, nor in the cycle the request rises.
- R7: The request falls only after the synchronized acknowledge has been seen high.
- R8: `in_ready` returns to 1 only after the synchronized acknowledge has been seen low and the request is low.
- R9: Words arrive in the order they were accepted, with no value corrupted, for all-zeros, all-ones and alternating bit patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Sending-domain clock |
| src_rst_n | input | 1 | Sending-domain asynchronous reset, active low |
| in_valid | input | 1 | A word is offered on `in_data` |
| in_ready | output | 1 | The sender can take a word |
| in_data | input | DATA_W | Word to transfer |
| dst_clk | input | 1 | Receiving-domain clock |
| dst_rst_n | input | 1 | Receiving-domain asynchronous reset, active low |
| out_valid | output | 1 | One-cycle strobe for a newly delivered word |
| out_data | output | DATA_W | Last delivered word |

## Verification
The bench keeps `in_valid` high with a different word while a transfer is pending. A sender that does not gate acceptance on `in_ready` would overwrite the frozen word or launch a second transfer, and the bench would see a wrong or extra word arrive. It counts strobes per transfer and checks that none spans two receiving cycles. An edge detector that slips back to a level test would repeat the word or lengthen the strobe. It also idles after a burst of mixed bit patterns and checks that the output word does not drift and no late strobe appears, which catches a capture register whose recirculation path is broken.

// File: rtl/word_handoff_pkg.sv
package word_handoff_pkg;

  typedef enum logic [1:0] {
    SND_IDLE      = 2'd0,
    SND_LAUNCH    = 2'd1,
    SND_WAIT_ACK  = 2'd2,
    SND_WAIT_DROP = 2'd3
  } snd_state_e;

endpackage

// File: rtl/bit_sync_chain.sv
module bit_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= 1'b0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/handoff_sender.sv
module handoff_sender
  import word_handoff_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              xreq,
  output logic [DATA_W-1:0] xdata,
  input  logic              xack
);

  snd_state_e        state_q, state_n;
  logic              req_q, req_n;
  logic [DATA_W-1:0] word_q;
  logic              load_en;
  logic              ack_s;

  bit_sync_chain #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (xack),
    .q_sync  (ack_s)
  );

  always_comb begin
    state_n = state_q;
    load_en = 1'b0;
    case (state_q)
      SND_IDLE: begin
        if (in_valid) begin
          load_en = 1'b1;
          state_n = SND_LAUNCH;
        end
      end
      SND_LAUNCH:    state_n = SND_WAIT_ACK;
      SND_WAIT_ACK:  if (ack_s)  state_n = SND_WAIT_DROP;
      SND_WAIT_DROP: if (!ack_s) state_n = SND_IDLE;
      default:       state_n = SND_IDLE;
    endcase
    req_n = (state_n == SND_WAIT_ACK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SND_IDLE;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      req_q   <= req_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (load_en) word_q <= in_data;
  end

  assign in_ready = (state_q == SND_IDLE);
  assign xreq     = req_q;
  assign xdata    = word_q;

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_word_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $stable(word_q));

  assert_req_drop_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q) |-> $past(ack_s));

  assert_ready_after_ack_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> (!$past(ack_s) && !$past(req_q)));

endmodule

// File: rtl/handoff_receiver.sv
module handoff_receiver #(
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xreq,
  input  logic [DATA_W-1:0] xdata,
  output logic              xack,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic              req_s;
  logic              seen_q;
  logic              take;
  logic              strobe_q;
  logic [DATA_W-1:0] cap_q, cap_n;

  bit_sync_chain #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (xreq),
    .q_sync  (req_s)
  );

  always_comb begin
    take  = req_s && !seen_q;
    cap_n = take ? xdata : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q   <= 1'b0;
      strobe_q <= 1'b0;
      cap_q    <= '0;
    end else begin
      seen_q   <= req_s;
      strobe_q <= take;
      cap_q    <= cap_n;
    end
  end

  assign xack      = seen_q;
  assign out_valid = strobe_q;
  assign out_data  = cap_q;

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_output_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

endmodule

// File: rtl/word_handoff_cdc.sv
module word_handoff_cdc #(
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic              xreq;
  logic              xack;
  logic [DATA_W-1:0] xdata;

  handoff_sender #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_sender (
    .clk      (src_clk),
    .rst_n    (src_rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .xreq     (xreq),
    .xdata    (xdata),
    .xack     (xack)
  );

  handoff_receiver #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_receiver (
    .clk       (dst_clk),
    .rst_n     (dst_rst_n),
    .xreq      (xreq),
    .xdata     (xdata),
    .xack      (xack),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: tb/word_handoff_cdc_tb_top.sv
module word_handoff_cdc_tb_top;

  localparam int DATA_W    = 16;
  localparam int SRC_CLK_T = 10;
  localparam int DST_CLK_T = 14;
  localparam int WATCHDOG  = 100000;

  logic              src_clk = 1'b0;
  logic              dst_clk = 1'b0;
  logic              src_rst_n = 1'b0;
  logic              dst_rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic              in_ready;
  logic              out_valid;
  logic [DATA_W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [DATA_W-1:0] rx_words [0:63];
  int rx_cnt = 0;
  int wide_cnt = 0;
  bit prev_valid = 1'b0;

  always #(SRC_CLK_T/2) src_clk = ~src_clk;
  always #(DST_CLK_T/2) dst_clk = ~dst_clk;

  word_handoff_cdc #(.DATA_W(DATA_W), .SYNC_STAGES(2)) dut_i (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // receiving-side monitor, sampled away from the active edge
  always @(negedge dst_clk) begin
    if (dst_rst_n) begin
      if (out_valid) begin
        if (rx_cnt < 64) rx_words[rx_cnt] <= out_data;
        rx_cnt <= rx_cnt + 1;
        if (prev_valid) wide_cnt <= wide_cnt + 1;
      end
      prev_valid <= out_valid;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!in_ready && n < 400) begin
      @(negedge src_clk);
      n++;
    end
    check(in_ready == 1'b1, req, "in_ready returns", in_ready, 1);
  endtask

  task automatic send_word(input logic [DATA_W-1:0] w);
    @(negedge src_clk);
    in_valid = 1'b1;
    in_data  = w;
    @(negedge src_clk);
    in_valid = 1'b0;
    in_data  = ~w;
  endtask

  task automatic settle();
    repeat (12) @(negedge dst_clk);
  endtask

  task automatic test_reset();
    @(negedge src_clk);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(out_data == '0, "R1", "out_data after reset", out_data, 0);
  endtask

  task automatic test_single();
    int base = rx_cnt;
    send_word(16'hA55A);
    check(in_ready == 1'b0, "R2", "in_ready low after accept", in_ready, 0);
    wait_ready("R8");
    settle();
    check(rx_cnt == base + 1, "R4", "one strobe per word", rx_cnt - base, 1);
    check(rx_words[base] == 16'hA55A, "R4", "delivered word", rx_words[base], 16'hA55A);
    check(wide_cnt == 0, "R4", "strobe width", wide_cnt, 0);
  endtask

  task automatic test_ignore_busy();
    int base = rx_cnt;
    send_word(16'h1234);
    in_valid = 1'b1;
    in_data  = 16'hDEAD;
    repeat (4) @(negedge src_clk);
    check(in_ready == 1'b0, "R2", "in_ready held low while busy", in_ready, 0);
    in_valid = 1'b0;
    wait_ready("R8");
    settle();
    check(rx_cnt == base + 1, "R3", "no extra word from busy valid", rx_cnt - base, 1);
    check(rx_words[base] == 16'h1234, "R3", "accepted word kept", rx_words[base], 16'h1234);
  endtask

  task automatic test_patterns();
    logic [DATA_W-1:0] pat [0:5];
    int base = rx_cnt;
    pat[0] = 16'h0000; pat[1] = 16'hFFFF; pat[2] = 16'hAAAA;
    pat[3] = 16'h5555; pat[4] = 16'h00FF; pat[5] = 16'h8001;
    for (int i = 0; i < 6; i++) begin
      send_word(pat[i]);
      wait_ready("R8");
    end
    settle();
    check(rx_cnt == base + 6, "R9", "word count", rx_cnt - base, 6);
    for (int i = 0; i < 6; i++)
      check(rx_words[base+i] == pat[i], "R9", "ordered word", rx_words[base+i], pat[i]);
    check(wide_cnt == 0, "R4", "no wide strobe in burst", wide_cnt, 0);
  endtask

  task automatic test_hold();
    int base = rx_cnt;
    repeat (30) @(negedge dst_clk);
    check(out_data == 16'h8001, "R5", "output held", out_data, 16'h8001);
    check(rx_cnt == base, "R5", "no late strobe", rx_cnt - base, 0);
    check(out_valid == 1'b0, "R5", "strobe idle", out_valid, 0);
  endtask

  initial begin : wd
    int n = 0;
    while (!finished && n < WATCHDOG) begin
      @(posedge src_clk);
      n++;
    end
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<%0d cycles", n, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge src_clk);
    src_rst_n = 1'b1;
    @(negedge dst_clk);
    dst_rst_n = 1'b1;
    test_reset();
    test_single();
    test_ignore_busy();
    test_patterns();
    test_hold();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule